// File: doc/BRIEF.md
# Two-Client Bus Request Arbiter

This block lets two on-chip bus masters, a video engine and an audio engine, share a single external bus request line and a single external grant. It merges the two client requests into the outgoing request, picks which client the incoming grant belongs to, and passes that grant to exactly one client. Audio wins when both are waiting, video is the parked default, and a client that has captured the bus keeps it until its transaction is over.

Two static mode inputs adapt the block to host chipsets that bend the bus rules. The first (`lock_en`) makes the outgoing request follow only the owning client while a grant is being used, so the other client cannot hold the line high. The second (`gate_en`) forwards the grant to a client only while the outgoing request is high, so no transaction can start as the grant is withdrawn. The cost is that the parked client can no longer use a grant it did not ask for.

All ports are active-high; any inversion of active-low bus pins happens outside this block. Outputs are combinational from the current client requests, the external grant and registered ownership state.

Top module: `busarb_top`

## Requirements
- R1: With `lock_en` low, `bus_req` equals `vid_req | aud_req` in every cycle.
- R2: With no ownership held, no client requesting and `gate_en` low, an asserted `ext_gnt` appears on `vid_gnt` (video is the parked client) and `aud_gnt` stays low.
- R3: With no ownership held, an asserted `aud_req` selects audio even if `vid_req` was raised earlier; a grant seen in that cycle goes to `aud_gnt`.
- R4: Ownership is captured at a rising clock edge where `ext_gnt` is high and the selected client requests; from then until release the selected client cannot change, even if the other client requests.
- R5: With `lock_en` high and ownership held, `bus_req` equals the owner's request alone, so it falls in the same cycle the owner drops its request; without ownership it is `vid_req | aud_req`.
- R6: Ownership is released at the first edge where `frame` and `irdy` are both low after `frame` was sampled high during the ownership; if `frame` was never sampled high, it is released at an edge where both `ext_gnt` and `frame` are low.
- R7: With `gate_en` high, `vid_gnt` and `aud_gnt` are low whenever `bus_req` is low; with `gate_en` low the grant is forwarded regardless of `bus_req`.
- R8: At most one of `vid_gnt`, `aud_gnt` is high, and neither is high while `ext_gnt` is low.
- R9: After reset no ownership is held and the selection rests on video.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_en | input | 1 | Static mode: route only the owner's request while owning |
| gate_en | input | 1 | Static mode: forward the grant only while the request is high |
| vid_req | input | 1 | Bus request from the video client |
| aud_req | input | 1 | Bus request from the audio client |
| ext_gnt | input | 1 | Grant from the external bus arbiter |
| frame | input | 1 | Bus cycle-frame signal, high while a transaction is in progress |
| irdy | input | 1 | Bus initiator-ready signal |
| bus_req | output | 1 | Merged request to the external bus arbiter |
| vid_gnt | output | 1 | Grant forwarded to the video client |
| aud_gnt | output | 1 | Grant forwarded to the audio client |

## Verification
The assertions assume `lock_en` and `gate_en` stay constant between resets and that all inputs change only away from the rising edge. The stimulus respects both: the mode bits are set once per sweep under reset, and every input is driven on the falling edge. Client requests, grant, `frame` and `irdy` otherwise move freely, including grant withdrawal without any transaction, so the release rules are reached through both paths.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

  typedef enum logic {
    CL_VID = 1'b0,
    CL_AUD = 1'b1
  } client_e;

  // Audio outranks video; video is the resting choice.
  function automatic client_e pick_client(input logic v_req, input logic a_req);
    return a_req ? CL_AUD : CL_VID;
  endfunction

  function automatic logic client_req(input client_e c, input logic v_req, input logic a_req);
    return (c == CL_AUD) ? a_req : v_req;
  endfunction

  function automatic logic merged_req(input logic lock_mode, input logic owning,
                                      input logic own_req, input logic v_req,
                                      input logic a_req);
    return (lock_mode && owning) ? own_req : (v_req | a_req);
  endfunction

  function automatic logic grant_pass(input logic gnt, input logic gate_mode,
                                      input logic req_out);
    return gnt && (!gate_mode || req_out);
  endfunction

endpackage

// File: rtl/busarb_select.sv
module busarb_select
  import busarb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    held,
  input  logic    vid_req,
  input  logic    aud_req,
  output client_e sel,
  output logic    sel_req
);

  client_e sel_q;

  // While owned, the stored choice stands; otherwise arbitrate afresh.
  assign sel     = held ? sel_q : pick_client(vid_req, aud_req);
  assign sel_req = client_req(sel, vid_req, aud_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= CL_VID;
    else        sel_q <= sel;
  end

  a_r3_audio_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && aud_req) |-> (sel == CL_AUD));

endmodule

// File: rtl/busarb_lock.sv
module busarb_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_gnt,
  input  logic frame,
  input  logic irdy,
  input  logic sel_req,
  output logic held,
  output logic started,
  output logic take,
  output logic release_ev
);

  logic held_q, started_q;
  logic bus_idle, keep;

  assign bus_idle   = !frame && !irdy;
  assign take       = !held_q && ext_gnt && sel_req;
  assign release_ev = held_q && ((started_q && bus_idle) ||
                                 (!started_q && !frame && !ext_gnt));
  assign keep       = held_q && !release_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      held_q    <= take | keep;
      started_q <= keep ? (started_q | frame) : 1'b0;
    end
  end

  assign held    = held_q;
  assign started = started_q;

  a_r6_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (held && started && !frame && !irdy) |=> !held);

  a_r6_release_withdrawn: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !started && !frame && !ext_gnt) |=> !held);

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && ext_gnt && sel_req) |=> held);

endmodule

// File: rtl/busarb_route.sv
module busarb_route
  import busarb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lock_en,
  input  logic    gate_en,
  input  logic    held,
  input  client_e sel,
  input  logic    sel_req,
  input  logic    vid_req,
  input  logic    aud_req,
  input  logic    ext_gnt,
  output logic    bus_req,
  output logic    vid_gnt,
  output logic    aud_gnt
);

  logic pass;

  assign bus_req = merged_req(lock_en, held, sel_req, vid_req, aud_req);
  assign pass    = grant_pass(ext_gnt, gate_en, bus_req);
  assign vid_gnt = pass && (sel == CL_VID);
  assign aud_gnt = pass && (sel == CL_AUD);

  a_r8_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vid_gnt, aud_gnt}) && (ext_gnt || !(vid_gnt || aud_gnt)));

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !bus_req) |-> !(vid_gnt || aud_gnt));

  a_r5_other_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_en && held && (sel == CL_VID) && !vid_req) |-> !bus_req);

  a_r1_plain_or: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_en && (vid_req || aud_req)) |-> bus_req);

endmodule

// File: rtl/busarb_top.sv
module busarb_top
  import busarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_en,
  input  logic gate_en,
  input  logic vid_req,
  input  logic aud_req,
  input  logic ext_gnt,
  input  logic frame,
  input  logic irdy,
  output logic bus_req,
  output logic vid_gnt,
  output logic aud_gnt
);

  client_e sel;
  logic    sel_req, held, started, take, release_ev;

  busarb_select u_select (
    .clk     (clk),
    .rst_n   (rst_n),
    .held    (held),
    .vid_req (vid_req),
    .aud_req (aud_req),
    .sel     (sel),
    .sel_req (sel_req)
  );

  busarb_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_gnt    (ext_gnt),
    .frame      (frame),
    .irdy       (irdy),
    .sel_req    (sel_req),
    .held       (held),
    .started    (started),
    .take       (take),
    .release_ev (release_ev)
  );

  busarb_route u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .lock_en (lock_en),
    .gate_en (gate_en),
    .held    (held),
    .sel     (sel),
    .sel_req (sel_req),
    .vid_req (vid_req),
    .aud_req (aud_req),
    .ext_gnt (ext_gnt),
    .bus_req (bus_req),
    .vid_gnt (vid_gnt),
    .aud_gnt (aud_gnt)
  );

  a_r4_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !release_ev) |=> (sel == $past(sel)));

  a_r3_audio_owns: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && aud_req && ext_gnt) |=> (held && sel == CL_AUD));

  a_r2_park_video: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && !vid_req && !aud_req && ext_gnt && !gate_en) |-> (vid_gnt && !aud_gnt));

  a_r6_started_only_held: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> held);

  a_r4_take_unheld: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !held);

endmodule

// File: tb/busarb_top_tb.sv
`timescale 1ns/1ps
module busarb_top_tb;

  logic clk = 1'b0;
  logic rst_n, lock_en, gate_en, vid_req, aud_req, ext_gnt, frame, irdy;
  logic bus_req, vid_gnt, aud_gnt;

  int total = 0;
  int bad = 0;

  // bench ownership model: 0 none, 1 video, 2 audio
  int   own;
  logic begun;
  logic o_req, o_vg, o_ag;

  always #2.5 clk = ~clk;

  busarb_top u_dut (
    .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .gate_en(gate_en),
    .vid_req(vid_req), .aud_req(aud_req), .ext_gnt(ext_gnt),
    .frame(frame), .irdy(irdy),
    .bus_req(bus_req), .vid_gnt(vid_gnt), .aud_gnt(aud_gnt)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, compare against the model before the edge, advance model
  task automatic step(input logic v, input logic a, input logic g,
                      input logic f, input logic i);
    int   who;
    logic who_req, e_req, e_pass;
    @(negedge clk);
    vid_req = v; aud_req = a; ext_gnt = g; frame = f; irdy = i;
    #1;
    who     = (own != 0) ? own : (a ? 2 : 1);
    who_req = (who == 2) ? a : v;
    e_req   = (lock_en && own != 0) ? who_req : (v | a);
    e_pass  = g && (!gate_en || e_req);
    o_req = bus_req; o_vg = vid_gnt; o_ag = aud_gnt;
    chk(lock_en ? "R5 request" : "R1 request", {2'b00, bus_req}, {2'b00, e_req});
    chk(gate_en ? "R7 grants" : "R8 grants", {1'b0, vid_gnt, aud_gnt},
        {1'b0, e_pass && who == 1, e_pass && who == 2});
    @(posedge clk);
    if (own == 0) begin
      if (g && who_req) begin own = who; begun = 1'b0; end
    end else if ((begun && !f && !i) || (!begun && !f && !g)) begin
      own = 0; begun = 1'b0;
    end else begin
      begun = begun | f;
    end
  endtask

  task automatic do_reset(input logic lk, input logic gt);
    @(negedge clk);
    rst_n = 1'b0; lock_en = lk; gate_en = gt;
    vid_req = 0; aud_req = 0; ext_gnt = 0; frame = 0; irdy = 0;
    own = 0; begun = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 outputs in reset", {bus_req, vid_gnt, aud_gnt}, 3'b000);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0;

    // directed: plain modes
    do_reset(1'b0, 1'b0);
    step(0, 0, 1, 0, 0);                       // parked grant, no capture
    chk("R9/R2 parked on video", {o_req, o_vg, o_ag}, 3'b010);
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);                       // audio arrives after video
    step(1, 1, 1, 0, 0);                       // grant seen: audio captures
    chk("R3 audio gets grant", {o_req, o_vg, o_ag}, 3'b101);
    step(1, 0, 1, 0, 0);                       // audio drops, video still asks
    chk("R4 no preemption", {o_req, o_vg, o_ag}, 3'b101);
    step(1, 0, 1, 1, 1);                       // transaction runs
    step(1, 0, 0, 0, 0);                       // idle: release at this edge
    step(1, 0, 1, 0, 0);
    chk("R6 released to video", {o_req, o_vg, o_ag}, 3'b110);

    // directed: lock mode
    do_reset(1'b1, 1'b0);
    step(1, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0);                       // audio captures
    step(1, 1, 1, 1, 0);
    chk("R5 owner request", {o_req, o_vg, o_ag}, 3'b101);
    step(1, 0, 0, 1, 1);                       // audio drops with frame
    chk("R5 other request masked", {o_req, o_vg, o_ag}, 3'b000);
    step(1, 0, 0, 0, 0);                       // idle releases
    step(1, 0, 0, 0, 0);
    chk("R5/R6 open again after release", {o_req, o_vg, o_ag}, 3'b100);

    // directed: gate mode and withdrawn grant
    do_reset(1'b0, 1'b1);
    step(0, 0, 1, 0, 0);
    chk("R7 no parked grant", {o_req, o_vg, o_ag}, 3'b000);
    step(1, 0, 1, 0, 0);                       // video captures
    step(0, 0, 0, 0, 0);                       // grant withdrawn, no frame
    step(0, 1, 1, 0, 0);
    chk("R6 withdrawn grant frees audio", {o_req, o_vg, o_ag}, 3'b101);

    // sweeps over all mode pairs
    lf = 16'hACE1;
    for (int m = 0; m < 4; m++) begin
      do_reset(m[1], m[0]);
      for (int c = 0; c < 3000; c++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[5] | lf[6], lf[7] & lf[8], lf[0] | lf[1],
             lf[2] & lf[3], lf[4] & lf[9]);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule